// File: doc/BRIEF.md
# Flow-Through Burst SRAM Cycle Controller

This block sits in front of a synchronous flow-through burst memory of four 8-bit byte lanes. It works out what the memory does on each clock. On every rising edge it captures the control inputs: three chip enables, a processor start strobe, a controller start strobe, a step strobe, a global write, a lane-write enable and four lane selects. It then decodes that captured set into one cycle class. The possible classes are idle, deselect, begin read, begin write, continue read, continue write, suspend read and suspend write.

The block drives two kinds of output from the cycle class. The first kind controls an external burst address counter through a load pulse and a step pulse. The second kind controls the storage array through per-lane write strobes and a data-drive enable.

Read data flows straight out of the array, so the class, the strobes and the drive enable are all combinational from the captured inputs. They are valid in the clock period that follows the capturing edge. The output enable and the sleep input are asynchronous and gate the outputs at once. Sleep also freezes capture. After sleep ends, the block stays idle until a new cycle is started.

Top module: `fts_cycle_ctrl`

## Requirements
- R1: The chip counts as selected when `en1_n`=0, `en2`=1 and `en3_n`=0. With `cpu_start_n`=0, `en1_n`=0 and the chip selected, the class is begin read (code 2), whatever the write inputs are.
- R2: With `en1_n`=1 the processor strobe is ignored. In that case `ctl_start_n`=0 gives deselect (code 1), and `ctl_start_n`=1 gives a continue or suspend class, exactly as if both strobes were high.
- R3: With `cpu_start_n`=0 and `en1_n`=0, the class is deselect (code 1) when `en2`=0 or `en3_n`=1.
- R4: With the processor strobe not acting and `ctl_start_n`=0 on a selected chip, the class is begin write (code 3) when a write condition holds, and begin read (code 2) otherwise. A write condition holds when `all_wr_n`=0, or when `lane_wr_n`=0 together with at least one `lane_sel_n` bit at 0.
- R5: With both strobes inactive, the class continues the direction of the last begin. It is continue read (4) or continue write (5) when `step_n`=0, and suspend read (6) or suspend write (7) when `step_n`=1. With no open burst (after reset, a deselect or sleep) the class is idle (0).
- R6: The write strobe `lane_we[i]` serves byte lane i, where lane 0 is data bits 7:0 and lane 3 is bits 31:24. `all_wr_n`=0 sets all four strobes. Otherwise `lane_we[i]` is 1 exactly when `lane_wr_n`=0 and `lane_sel_n[i]`=0.
- R7: `lane_we` is all zero in every class other than begin write, continue write and suspend write.
- R8: `dq_drive` is 1 only in classes 2, 4 and 6, and only while `out_en_n`=0 and `sleep`=0. `out_en_n` takes effect without waiting for a clock edge.
- R9: While `sleep`=1, the class reads idle and `lane_we`, `dq_drive`, `addr_load` and `addr_step` are all 0, starting at once. No input is captured while `sleep`=1. After release the class stays idle until a new begin cycle is captured.
- R10: Inputs are captured on the rising edge of `clk`, and the outputs for them hold during the following period. `addr_load` is 1 in classes 2 and 3. `addr_step` is 1 in classes 4 and 5. The two are never 1 together.
- R11: While `rst_n`=0 and right after it, the class is idle (0) and all strobes and enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en1_n | input | 1 | First chip enable, active low; gates the processor strobe |
| en2 | input | 1 | Second chip enable, active high |
| en3_n | input | 1 | Third chip enable, active low |
| cpu_start_n | input | 1 | Processor start strobe, active low, always starts a read |
| ctl_start_n | input | 1 | Controller start strobe, active low |
| step_n | input | 1 | Step burst address when low, hold when high |
| all_wr_n | input | 1 | Global write of all lanes, active low |
| lane_wr_n | input | 1 | Enable for per-lane writes, active low |
| lane_sel_n | input | 4 | Per-lane write selects, active low, bit i = lane i |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous sleep, active high |
| cyc_kind | output | 3 | Cycle class code 0..7 |
| addr_load | output | 1 | Load the external address into the burst counter |
| addr_step | output | 1 | Step the burst counter |
| lane_we | output | 4 | Per-lane write strobes to the array |
| dq_drive | output | 1 | Drive enable for the read data bus |

## Verification
Every clocked result (class, load, step and lane strobes) depends on one capture register only. It is therefore due in the period right after the edge that takes in the stimulus. The bench changes inputs on the falling edge and checks on the next falling edge. Continue and suspend classes also depend on the burst direction latched at the edge before, so those tests set up a begin cycle first and check one period later. The output enable and sleep gate the outputs with no register in between, so the bench checks those 1 ns after changing the pin, with no clock edge in the gap.

// File: rtl/fts_pkg.sv
package fts_pkg;

  typedef enum logic [2:0] {
    CY_IDLE  = 3'd0,
    CY_DESEL = 3'd1,
    CY_BRD   = 3'd2,
    CY_BWR   = 3'd3,
    CY_CRD   = 3'd4,
    CY_CWR   = 3'd5,
    CY_SRD   = 3'd6,
    CY_SWR   = 3'd7
  } cyc_e;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;

  typedef struct packed {
    logic en1_n;
    logic en2;
    logic en3_n;
    logic cpu_n;
    logic ctl_n;
    logic step_n;
    logic all_wr_n;
    logic lane_wr_n;
  } ctl_s;

  localparam ctl_s CTL_QUIET = '{en1_n: 1'b1, en2: 1'b0, en3_n: 1'b1,
                                 cpu_n: 1'b1, ctl_n: 1'b1, step_n: 1'b1,
                                 all_wr_n: 1'b1, lane_wr_n: 1'b1};

  function automatic logic is_wr_class(cyc_e k);
    return (k == CY_BWR) || (k == CY_CWR) || (k == CY_SWR);
  endfunction

  function automatic logic is_rd_class(cyc_e k);
    return (k == CY_BRD) || (k == CY_CRD) || (k == CY_SRD);
  endfunction

endpackage

// File: rtl/fts_in_reg.sv
module fts_in_reg
  import fts_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleep,
  input  ctl_s             d_ctl,
  input  logic [LANES-1:0] d_sel_n,
  output ctl_s             q_ctl,
  output logic [LANES-1:0] q_sel_n
);

  // Capture is frozen in sleep; strobes are parked inactive so that
  // stale starts cannot replay once sleep ends.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_ctl   <= CTL_QUIET;
      q_sel_n <= '1;
    end else if (sleep) begin
      q_ctl   <= CTL_QUIET;
    end else begin
      q_ctl   <= d_ctl;
      q_sel_n <= d_sel_n;
    end
  end

  AST_SLEEP_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> (q_ctl.cpu_n && q_ctl.ctl_n)); // R9

endmodule

// File: rtl/fts_lane_wr.sv
module fts_lane_wr #(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             all_wr_n,
  input  logic             lane_wr_n,
  input  logic [LANES-1:0] lane_sel_n,
  output logic [LANES-1:0] strobe,
  output logic             wr_cond
);

  logic [LANES-1:0] picked;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign picked[i] = ~lane_wr_n & ~lane_sel_n[i];
    assign strobe[i] = ~all_wr_n | picked[i];
  end

  assign wr_cond = ~all_wr_n | (|picked);

  AST_GLOBAL_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    !all_wr_n |-> (&strobe)); // R6
  AST_LANE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (all_wr_n && lane_wr_n) |-> (strobe == '0)); // R6

endmodule

// File: rtl/fts_cycle_dec.sv
module fts_cycle_dec
  import fts_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  ctl_s q,
  input  logic wr_cond,
  input  op_e  op,
  output cyc_e kind
);

  logic sel;
  logic cpu_go;

  assign sel    = ~q.en1_n & q.en2 & ~q.en3_n;
  assign cpu_go = ~q.cpu_n & ~q.en1_n;

  always_comb begin
    kind = CY_IDLE;
    if (cpu_go) begin
      kind = sel ? CY_BRD : CY_DESEL;
    end else if (!q.ctl_n) begin
      if (!sel)         kind = CY_DESEL;
      else if (wr_cond) kind = CY_BWR;
      else              kind = CY_BRD;
    end else begin
      unique case (op)
        OP_RD:   kind = q.step_n ? CY_SRD : CY_CRD;
        OP_WR:   kind = q.step_n ? CY_SWR : CY_CWR;
        default: kind = CY_IDLE;
      endcase
    end
  end

  AST_BEGIN_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == CY_BRD || kind == CY_BWR) |-> (!q.en1_n && q.en2 && !q.en3_n)); // R1
  AST_CPU_NEVER_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    (!q.cpu_n && !q.en1_n) |-> (kind != CY_BWR)); // R1

endmodule

// File: rtl/fts_cycle_ctrl.sv
module fts_cycle_ctrl
  import fts_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en1_n,
  input  logic             en2,
  input  logic             en3_n,
  input  logic             cpu_start_n,
  input  logic             ctl_start_n,
  input  logic             step_n,
  input  logic             all_wr_n,
  input  logic             lane_wr_n,
  input  logic [LANES-1:0] lane_sel_n,
  input  logic             out_en_n,
  input  logic             sleep,
  output logic [2:0]       cyc_kind,
  output logic             addr_load,
  output logic             addr_step,
  output logic [LANES-1:0] lane_we,
  output logic             dq_drive
);

  ctl_s             d_ctl;
  ctl_s             q_ctl;
  logic [LANES-1:0] q_sel_n;
  logic [LANES-1:0] strobe;
  logic             wr_cond;
  cyc_e             kind_raw;
  cyc_e             kind;
  op_e              op_q;

  assign d_ctl = '{en1_n: en1_n, en2: en2, en3_n: en3_n,
                   cpu_n: cpu_start_n, ctl_n: ctl_start_n, step_n: step_n,
                   all_wr_n: all_wr_n, lane_wr_n: lane_wr_n};

  fts_in_reg #(.LANES(LANES)) u_in_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .sleep   (sleep),
    .d_ctl   (d_ctl),
    .d_sel_n (lane_sel_n),
    .q_ctl   (q_ctl),
    .q_sel_n (q_sel_n)
  );

  fts_lane_wr #(.LANES(LANES)) u_lane_wr (
    .clk        (clk),
    .rst_n      (rst_n),
    .all_wr_n   (q_ctl.all_wr_n),
    .lane_wr_n  (q_ctl.lane_wr_n),
    .lane_sel_n (q_sel_n),
    .strobe     (strobe),
    .wr_cond    (wr_cond)
  );

  fts_cycle_dec u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .q       (q_ctl),
    .wr_cond (wr_cond),
    .op      (op_q),
    .kind    (kind_raw)
  );

  // Burst direction: opened by a begin, closed by deselect, idle or sleep.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q <= OP_NONE;
    end else if (sleep) begin
      op_q <= OP_NONE;
    end else begin
      unique case (kind_raw)
        CY_BRD:            op_q <= OP_RD;
        CY_BWR:            op_q <= OP_WR;
        CY_DESEL, CY_IDLE: op_q <= OP_NONE;
        default:           op_q <= op_q;
      endcase
    end
  end

  // Asynchronous gating of everything by sleep and output enable.
  assign kind      = sleep ? CY_IDLE : kind_raw;
  assign cyc_kind  = kind;
  assign addr_load = (kind == CY_BRD) || (kind == CY_BWR);
  assign addr_step = (kind == CY_CRD) || (kind == CY_CWR);
  assign lane_we   = is_wr_class(kind) ? strobe : '0;
  assign dq_drive  = is_rd_class(kind) && !out_en_n && !sleep;

  AST_DRIVE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    dq_drive |-> (!out_en_n && !sleep)); // R8
  AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> (lane_we == '0 && cyc_kind == 3'd0 && !addr_load)); // R9
  AST_WE_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (|lane_we) |-> (cyc_kind == 3'd3 || cyc_kind == 3'd5 || cyc_kind == 3'd7)); // R7
  AST_BEGIN_OPENS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && kind_raw == CY_BRD) |=> (op_q == OP_RD)); // R5
  AST_DESEL_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_raw == CY_DESEL) |=> (op_q == OP_NONE)); // R5
  AST_LOAD_STEP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({addr_load, addr_step})); // R10

endmodule

// File: tb/fts_cycle_ctrl_tb.sv
module fts_cycle_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en1_n, en2, en3_n, cpu_start_n, ctl_start_n, step_n;
  logic       all_wr_n, lane_wr_n, out_en_n, sleep;
  logic [3:0] lane_sel_n;
  logic [2:0] cyc_kind;
  logic       addr_load, addr_step, dq_drive;
  logic [3:0] lane_we;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  fts_cycle_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .en1_n(en1_n), .en2(en2), .en3_n(en3_n),
    .cpu_start_n(cpu_start_n), .ctl_start_n(ctl_start_n), .step_n(step_n),
    .all_wr_n(all_wr_n), .lane_wr_n(lane_wr_n), .lane_sel_n(lane_sel_n),
    .out_en_n(out_en_n), .sleep(sleep), .cyc_kind(cyc_kind),
    .addr_load(addr_load), .addr_step(addr_step), .lane_we(lane_we),
    .dq_drive(dq_drive)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic outs(input string req, input int k, input int ld, input int st,
                      input int we, input int dr);
    chk(req, "kind", cyc_kind, k);
    chk(req, "load", addr_load, ld);
    chk(req, "step", addr_step, st);
    chk(req, "lane_we", lane_we, we);
    chk(req, "drive", dq_drive, dr);
  endtask

  // en1_n en2 en3_n cpu ctl step allw lanew sel
  task automatic drv(input logic a, input logic b, input logic c, input logic p,
                     input logic q, input logic s, input logic g, input logic w,
                     input logic [3:0] l);
    en1_n = a; en2 = b; en3_n = c; cpu_start_n = p; ctl_start_n = q;
    step_n = s; all_wr_n = g; lane_wr_n = w; lane_sel_n = l;
  endtask

  task automatic quiet();
    drv(1, 0, 1, 1, 1, 1, 1, 1, 4'hF);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    outs("R11", 0, 0, 0, 0, 0);
    tick();
    outs("R11", 0, 0, 0, 0, 0);
  endtask

  task automatic t_cpu_read();
    drv(0, 1, 0, 0, 1, 1, 0, 0, 4'h0); tick();  // write inputs active, still read
    outs("R1", 2, 1, 0, 0, 1);
    drv(0, 1, 0, 0, 0, 1, 0, 0, 4'h0); tick();  // both strobes low: cpu wins
    outs("R1", 2, 1, 0, 0, 1);
    quiet(); tick();
  endtask

  task automatic t_deselects();
    drv(0, 0, 0, 0, 1, 1, 1, 1, 4'hF); tick();
    outs("R3", 1, 0, 0, 0, 0);
    drv(0, 1, 1, 0, 1, 1, 1, 1, 4'hF); tick();
    outs("R3", 1, 0, 0, 0, 0);
    drv(1, 1, 0, 1, 0, 1, 0, 1, 4'hF); tick();
    outs("R2", 1, 0, 0, 0, 0);
    drv(1, 1, 0, 0, 1, 0, 1, 1, 4'hF); tick();  // cpu ignored, no burst open
    outs("R2", 0, 0, 0, 0, 0);
  endtask

  task automatic t_ctl_writes();
    drv(0, 1, 0, 1, 0, 1, 0, 1, 4'hF); tick();
    outs("R4", 3, 1, 0, 15, 0);
    drv(0, 1, 0, 1, 0, 1, 1, 0, 4'b1010); tick();
    outs("R6", 3, 1, 0, 4'b0101, 0);
    drv(0, 1, 0, 1, 0, 1, 1, 0, 4'b0111); tick();
    outs("R6", 3, 1, 0, 4'b1000, 0);
    drv(0, 1, 0, 1, 0, 1, 1, 0, 4'hF); tick();  // enable but no lane
    outs("R4", 2, 1, 0, 0, 1);
    drv(0, 1, 0, 1, 0, 1, 1, 1, 4'h0); tick();  // lanes but no enable
    outs("R7", 2, 1, 0, 0, 1);
  endtask

  task automatic t_bursts();
    drv(0, 1, 0, 1, 0, 1, 1, 0, 4'b1110); tick();
    outs("R6", 3, 1, 0, 1, 0);
    drv(1, 0, 1, 1, 1, 0, 1, 0, 4'b0111); tick();
    outs("R5", 5, 0, 1, 8, 0);
    drv(1, 0, 1, 1, 1, 1, 0, 1, 4'hF); tick();
    outs("R5", 7, 0, 0, 15, 0);
    drv(0, 1, 0, 0, 1, 1, 1, 1, 4'hF); tick();
    outs("R1", 2, 1, 0, 0, 1);
    drv(1, 0, 1, 0, 1, 0, 0, 1, 4'hF); tick();  // cpu low but en1 high: continue
    outs("R2", 4, 0, 1, 0, 1);
    drv(1, 0, 1, 1, 1, 1, 0, 1, 4'hF); tick();
    outs("R7", 6, 0, 0, 0, 1);
    drv(1, 1, 0, 1, 0, 1, 1, 1, 4'hF); tick();
    outs("R10", 1, 0, 0, 0, 0);
    quiet(); tick();
    outs("R5", 0, 0, 0, 0, 0);
  endtask

  task automatic t_oe();
    drv(0, 1, 0, 0, 1, 1, 1, 1, 4'hF); tick();
    quiet();
    out_en_n = 1'b1; #1;
    chk("R8", "drive oe high", dq_drive, 0);
    out_en_n = 1'b0; #1;
    chk("R8", "drive oe low", dq_drive, 1);
    tick();
  endtask

  task automatic t_sleep();
    drv(0, 1, 0, 0, 1, 1, 1, 1, 4'hF); tick();
    sleep = 1'b1; #1;
    outs("R9", 0, 0, 0, 0, 0);
    drv(0, 1, 0, 1, 0, 1, 0, 1, 4'hF); tick();  // begin write while asleep
    outs("R9", 0, 0, 0, 0, 0);
    tick();
    quiet();
    sleep = 1'b0; #1;
    outs("R9", 0, 0, 0, 0, 0);
    tick();
    outs("R9", 0, 0, 0, 0, 0);
    drv(0, 1, 0, 1, 0, 1, 0, 1, 4'hF); tick();
    outs("R9", 3, 1, 0, 15, 0);
    quiet(); tick();
  endtask

  initial begin
    quiet();
    out_en_n = 1'b0;
    sleep = 1'b0;
    repeat (3) @(negedge clk);
    outs("R11", 0, 0, 0, 0, 0);
    rst_n = 1'b1;
    t_reset();
    t_cpu_read();
    t_deselects();
    t_ctl_writes();
    t_bursts();
    t_oe();
    t_sleep();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule